// File: doc/BRIEF.md
# Near-Full-Scale Level Flag with Retriggerable Hold

This block watches a stereo pair of 18-bit two's-complement audio samples and raises a single level flag when either channel comes within about 1 dB of digital full scale. After that the flag stays up for a programmable number of sample periods, so a slow observer such as a polling controller or an indicator driver cannot miss a short peak. Every further near-full-scale sample restarts the hold period in full.

Samples are accepted only on cycles where the sample-valid strobe is high. The hold counter also counts down only on those strobes, so the hold time is measured in sample periods and not in clock cycles. While standby is asserted the flag is held low at once, the hold state is discarded and strobes are ignored.

Top module: `ovl_hold_detect`

## Requirements
- R1: A positive sample (bit 17 clear, two's complement) whose value is at least THRESH_MAG (default 116823, about 1 dB below 131071) counts as a violation.
- R2: A negative sample whose magnitude is at least THRESH_MAG counts as a violation. This includes the most negative code −131072, whose magnitude must not wrap.
- R3: A sample whose magnitude is THRESH_MAG−1 or less, on both channels, never raises the flag.
- R4: A violation on the left channel alone, or on the right channel alone, is enough to raise the flag.
- R5: The flag goes high on the first clock edge after a strobed violation.
- R6: Once no further violations arrive, the flag stays high through HOLD_CNT (default 512) clean strobes. It is low in the cycle that follows the HOLD_CNT-th clean strobe.
- R7: A new violation while the flag is high reloads the full hold count.
- R8: Without a strobe, the sample inputs are ignored and the hold state does not change.
- R9: While standby is high, the flag is low in the same cycle and strobes are ignored. The hold state is cleared, so the flag stays low after standby ends until a new violation arrives.
- R10: Reset clears the flag and the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| stby | input | 1 | Standby: forces the flag low and clears the hold |
| smp_vld | input | 1 | Sample-valid strobe, one per sample period |
| smp_l | input | SAMPLE_W | Left sample, two's complement |
| smp_r | input | SAMPLE_W | Right sample, two's complement |
| ovl_flag | output | 1 | Near-full-scale flag, held high after a violation |

## Verification
A wrong magnitude in the comparator shows up on the flag at the first clock edge after the strobe carrying the offending code. The sweeps around ±THRESH_MAG and at the two extreme codes catch this within one strobe. A wrong hold count shows up later, as an edge that comes too early or too late. It appears within HOLD_CNT strobes of the last violation, so the bench runs with a short hold and compares the flag after every step. A hold state that survives standby or reset shows up as a flag that is still high at the first clean strobe after release.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   localparam int unsigned OVL_NUM_CH = 2;
   typedef enum logic [0:0] {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} ovl_ch_e;
endpackage

// File: rtl/ovl_mag_cmp.sv
module ovl_mag_cmp #(
   parameter int unsigned SAMPLE_W   = 18,
   parameter int unsigned THRESH_MAG = 116823
) (
   input  logic [SAMPLE_W-1:0] smp,
   output logic                hit
);
   localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(THRESH_MAG);

   generate
      if (THRESH_MAG == 0 || THRESH_MAG >= (64'd1 << (SAMPLE_W-1))) begin : g_bad_thr
         $error("ovl_mag_cmp: THRESH_MAG out of range");
      end
   endgenerate

   // Unsigned magnitude in SAMPLE_W bits: the most negative code maps to 2^(W-1) without wrapping
   logic [SAMPLE_W-1:0] mag;
   always_comb begin
      mag = smp[SAMPLE_W-1] ? (~smp + SAMPLE_W'(1)) : smp;
      hit = (mag >= THR);
   end
endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer #(
   parameter int unsigned HOLD_CNT = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby,
   input  logic tick,
   input  logic trig,
   output logic active
);
   localparam int unsigned CNT_W = $clog2(HOLD_CNT + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CNT);

   generate
      if (HOLD_CNT < 1) begin : g_bad_hold
         $error("ovl_hold_timer: HOLD_CNT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (stby)                  cnt_q <= '0;
      else if (tick && trig)          cnt_q <= LOAD;
      else if (tick && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
   end

   assign active = (cnt_q != '0);

   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
   a_r7_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && trig && !stby) |=> (cnt_q == LOAD));
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !stby) |=> $stable(cnt_q));
   a_r9_stby_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stby |=> (cnt_q == '0));
endmodule

// File: rtl/ovl_hold_detect.sv
module ovl_hold_detect #(
   parameter int unsigned SAMPLE_W   = 18,
   parameter int unsigned THRESH_MAG = 116823,
   parameter int unsigned HOLD_CNT   = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stby,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_l,
   input  logic [SAMPLE_W-1:0] smp_r,
   output logic                ovl_flag
);
   import ovl_pkg::*;

   localparam logic [SAMPLE_W-1:0] NEG_FS = SAMPLE_W'(1) << (SAMPLE_W-1);

   logic [SAMPLE_W-1:0] ch_smp [OVL_NUM_CH];
   logic [OVL_NUM_CH-1:0] ch_hit;
   logic any_hit;
   logic hold_on;

   assign ch_smp[CH_LEFT]  = smp_l;
   assign ch_smp[CH_RIGHT] = smp_r;

   generate
      for (genvar c = 0; c < OVL_NUM_CH; c++) begin : g_ch
         ovl_mag_cmp #(
            .SAMPLE_W   (SAMPLE_W),
            .THRESH_MAG (THRESH_MAG)
         ) u_cmp (
            .smp (ch_smp[c]),
            .hit (ch_hit[c])
         );
      end
   endgenerate

   assign any_hit = |ch_hit;

   ovl_hold_timer #(
      .HOLD_CNT (HOLD_CNT)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .stby   (stby),
      .tick   (smp_vld),
      .trig   (any_hit),
      .active (hold_on)
   );

   assign ovl_flag = hold_on & ~stby;

   a_r5_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !stby && any_hit) |=> (ovl_flag || stby));
   a_r2_neg_fullscale: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !stby && (smp_l == NEG_FS || smp_r == NEG_FS)) |=> (ovl_flag || stby));
   a_r3_zero_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_l == '0 && smp_r == '0) |-> !any_hit);
   a_r8_no_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !ovl_flag) |=> !ovl_flag);
endmodule

// File: tb/ovl_hold_detect_bench.sv
module ovl_hold_detect_bench;
   localparam int HOLD = 8;
   localparam int THR  = 116823;

   logic clk = 1'b0;
   logic rst_n, stby, smp_vld;
   logic [17:0] smp_l, smp_r;
   logic ovl_flag;

   int n_run = 0, n_fail = 0, m_cnt = 0;

   always #10 clk = ~clk;

   ovl_hold_detect #(.SAMPLE_W(18), .THRESH_MAG(THR), .HOLD_CNT(HOLD)) u_ovl_hold_detect (
      .clk(clk), .rst_n(rst_n), .stby(stby), .smp_vld(smp_vld),
      .smp_l(smp_l), .smp_r(smp_r), .ovl_flag(ovl_flag));

   function automatic bit hitf(input int v);
      int a = (v < 0) ? -v : v;
      return a >= THR;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flag=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // drive at negedge, model the edge, compare at the following negedge
   task automatic step(input logic v, input int l, input int r, input string tag);
      smp_vld = v; smp_l = 18'(l); smp_r = 18'(r);
      @(posedge clk);
      if (!rst_n || stby) m_cnt = 0;
      else if (v) begin
         if (hitf(l) || hitf(r)) m_cnt = HOLD;
         else if (m_cnt > 0) m_cnt--;
      end
      @(negedge clk);
      check(tag, ovl_flag, (m_cnt > 0) && !stby);
   endtask

   task automatic clear_hold();
      stby = 1'b1;
      step(1'b0, 0, 0, "R9");
      stby = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int pts[16];
      rst_n = 1'b0; stby = 1'b0; smp_vld = 1'b0; smp_l = '0; smp_r = '0;
      repeat (3) @(negedge clk);
      check("R10", ovl_flag, 1'b0);
      rst_n = 1'b1;

      // threshold sweep, each channel alone
      pts = '{THR-4, THR-2, THR-1, THR, THR+1, THR+3, 131071, 0,
              -(THR-3), -(THR-1), -THR, -(THR+1), -(THR+4), -131072, -1, 100000};
      for (int ch = 0; ch < 2; ch++) begin
         foreach (pts[i]) begin
            string tag;
            int v = pts[i];
            if (!hitf(v)) tag = "R3";
            else if (v < 0) tag = (ch == 0) ? "R2" : "R4";
            else tag = (ch == 0) ? "R1" : "R4";
            if (ch == 0) step(1'b1, v, 0, tag);
            else step(1'b1, 0, v, tag);
            clear_hold();
         end
      end
      // both channels just below threshold
      step(1'b1, THR-1, -(THR-1), "R3");

      // hold length with idle gaps and ignored large samples (R6, R8)
      step(1'b1, 131071, 0, "R5");
      for (int k = 0; k < HOLD; k++) begin
         step(1'b0, -131072, 131071, "R8");
         step(1'b1, 1000, -1000, "R6");
      end
      step(1'b0, 131071, 131071, "R8");

      // retrigger (R7)
      step(1'b1, 0, -131072, "R5");
      for (int k = 0; k < 5; k++) step(1'b1, 0, 0, "R6");
      step(1'b1, THR, 0, "R7");
      for (int k = 0; k < HOLD; k++) step(1'b1, 0, 0, "R7");

      // standby: immediate low, strobes ignored, hold discarded (R9)
      step(1'b1, 131071, 0, "R5");
      stby = 1'b1; #1;
      check("R9", ovl_flag, 1'b0);
      step(1'b1, 131071, -131072, "R9");
      step(1'b1, 131071, 0, "R9");
      stby = 1'b0;
      step(1'b1, 0, 0, "R9");

      // reset during hold (R10)
      step(1'b1, -131072, 0, "R5");
      rst_n = 1'b0;
      step(1'b1, 131071, 0, "R10");
      rst_n = 1'b1;
      step(1'b1, 0, 0, "R10");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule